// File: doc/BRIEF.md
# Sync Tip and Back-Porch Gate Timer

This block takes a composite-sync signal that an analog comparator has already turned into a logic level, and a free-running system clock. From them it produces two capture gates for downstream sample-and-hold or averaging logic. The tip gate marks the window in which the sync-tip level should be captured. The back-porch gate marks the window for the blanking level that follows the pulse.

Each low-going (leading) sync edge starts a delay. The tip gate opens when the delay ends and then stays open for a fixed width. The high-going (trailing) edge ends the tip gate at once if it is still open, so a capture never runs past the end of the tip. A one-cycle status pulse reports when this happens. The same trailing edge starts a separate one-shot that times the back-porch gate.

All three durations come from nanosecond parameters and the clock frequency. A small rate-select input divides all three durations by the same factor, so the windows follow the scan rate in use. A new leading edge always restarts the sequence from the delay phase, even when a gate is still open.

Top module: `sync_gate_timer`

## Requirements
- R1: While rstN is low and on the first cycle after it rises, tipGate, bpGate and tipCut are all 0 when syncIn is held high.
- R2: syncIn passes through a two-flop synchroniser. A change of syncIn that is present at clock edge k takes effect at edge k+2, which is the edge where a phase starts.
- R3: A low-going syncIn edge that takes effect at edge e opens tipGate at edge e+D. D = max(1, floor(TIP_DELAY_NS·CLK_HZ/1e9 / r)), which is 40 at 50 MHz with r = 1.
- R4: Once open and left alone, tipGate stays high for exactly W cycles and then closes by itself. W is defined like D but from TIP_WIDTH_NS, which gives 100 at base rate.
- R5: Suppose a high-going edge takes effect at edge e while tipGate is high. Then tipGate is 0 after edge e, and tipCut is 1 for the single cycle after edge e.
- R6: Suppose a high-going edge takes effect while the delay phase is still running. Then tipGate never opens for that pulse, and tipCut stays 0.
- R7: Every high-going edge that takes effect at edge e raises bpGate at edge e for B cycles. B is defined like D but from BP_WIDTH_NS, which gives 125 at base rate.
- R8: A low-going edge that takes effect while bpGate or tipGate is high drops both gates at that edge and restarts the delay phase.
- R9: rateSel is an unsigned divider r in the range 1..15, and the value 0 acts as 1. It is sampled at the edge where each duration is loaded, and every loaded count is at least 1.
- R10: tipGate and bpGate are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Digitised composite sync, low during the sync pulse |
| rateSel | input | RATE_W | Scan-rate divider applied to all durations |
| tipGate | output | 1 | Sync-tip capture window |
| bpGate | output | 1 | Back-porch capture window |
| tipCut | output | 1 | One-cycle pulse when a trailing edge ends the tip window early |

## Verification
The hardest cases to reach from the ports are the two ways a sequence is cut short. In one, a trailing edge lands inside the tip window, or even before the window has opened. In the other, a leading edge arrives while the back-porch window is still running. Either one needs the sync pulse width, relative to the rate-scaled counts, to fall within a window of a few cycles. The stimulus therefore includes directed pulses sized to land before, inside and after the tip window, and a short high interval that cuts the back-porch gate. On top of these come random low and high widths with random rate values, which cover the minimum counts at the highest divider. Each cycle is compared against windows that the bench computes from its own edge times.

// File: rtl/sync_gate_pkg.sv
package sync_gate_pkg;

  typedef enum logic [1:0] {
    SEL_DELAY = 2'd0,
    SEL_TIP   = 2'd1,
    SEL_BP    = 2'd2
  } cntSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_TIP   = 2'd2,
    ST_BP    = 2'd3
  } gateState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    cntSel_e sel;
  } ctlStrobe_t;

  function automatic int nsToCycles(input longint clkHz, input longint ns);
    longint prod;
    prod = (clkHz / 64'd1000) * ns;
    return int'(prod / 64'd1000000);
  endfunction

  // divide a base count by a rate value, zero treated as one, never below 1
  function automatic int scaledCount(input int base, input int rate);
    int r;
    int q;
    r = (rate == 0) ? 1 : rate;
    q = base / r;
    return (q < 1) ? 1 : q;
  endfunction

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sync_gate_dp.sv
module sync_gate_dp
  import sync_gate_pkg::*;
#(
  parameter int RATE_W     = 4,
  parameter int CNT_W      = 8,
  parameter int DELAY_BASE = 40,
  parameter int TIP_BASE   = 100,
  parameter int BP_BASE    = 125
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [RATE_W-1:0] rateSel,
  input  ctlStrobe_t        strobe,
  output logic              fallEdge,
  output logic              riseEdge,
  output logic              cntLast
);

  localparam int RATES = 1 << RATE_W;

  logic syncMeta;
  logic syncStable;
  logic syncPrev;

  // R2: two-flop synchroniser plus one history flop, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncMeta   <= 1'b1;
      syncStable <= 1'b1;
      syncPrev   <= 1'b1;
    end else begin
      syncMeta   <= syncIn;
      syncStable <= syncMeta;
      syncPrev   <= syncStable;
    end
  end

  assign fallEdge = syncPrev & ~syncStable;
  assign riseEdge = ~syncPrev & syncStable;

  // rate-scaled count tables, one entry per rate code
  logic [CNT_W-1:0] delayTab [RATES];
  logic [CNT_W-1:0] tipTab   [RATES];
  logic [CNT_W-1:0] bpTab    [RATES];

  for (genvar gi = 0; gi < RATES; gi++) begin : g_tab
    localparam int DV = scaledCount(DELAY_BASE, gi);
    localparam int TV = scaledCount(TIP_BASE, gi);
    localparam int BV = scaledCount(BP_BASE, gi);
    assign delayTab[gi] = CNT_W'(DV);
    assign tipTab[gi]   = CNT_W'(TV);
    assign bpTab[gi]    = CNT_W'(BV);
  end

  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (strobe.sel)
      SEL_DELAY: loadVal = delayTab[rateSel];
      SEL_TIP:   loadVal = tipTab[rateSel];
      SEL_BP:    loadVal = bpTab[rateSel];
      default:   loadVal = bpTab[rateSel];
    endcase
  end

  logic [CNT_W-1:0] cnt;

  // single shared down-counter, parks at zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntLast = (cnt == CNT_W'(1));

  // R9
  load_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> cnt != '0);

endmodule

// File: rtl/sync_gate_ctrl.sv
module sync_gate_ctrl
  import sync_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       fallEdge,
  input  logic       riseEdge,
  input  logic       cntLast,
  output ctlStrobe_t strobe,
  output logic       tipGate,
  output logic       bpGate,
  output logic       tipCut
);

  gateState_e state;
  gateState_e stateNext;
  logic       cutNext;

  always_comb begin
    stateNext     = state;
    strobe.load   = 1'b0;
    strobe.sel    = SEL_DELAY;
    cutNext       = 1'b0;
    if (fallEdge) begin
      // R8: leading edge always restarts from the delay phase
      stateNext   = ST_DELAY;
      strobe.load = 1'b1;
      strobe.sel  = SEL_DELAY;
    end else if (riseEdge) begin
      // R5, R6, R7: trailing edge ends any tip phase and starts back porch
      stateNext   = ST_BP;
      strobe.load = 1'b1;
      strobe.sel  = SEL_BP;
      cutNext     = (state == ST_TIP);
    end else begin
      unique case (state)
        ST_DELAY: if (cntLast) begin
          stateNext   = ST_TIP;
          strobe.load = 1'b1;
          strobe.sel  = SEL_TIP;
        end
        ST_TIP:   if (cntLast) stateNext = ST_IDLE;
        ST_BP:    if (cntLast) stateNext = ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      tipCut <= 1'b0;
    end else begin
      state  <= stateNext;
      tipCut <= cutNext;
    end
  end

  assign tipGate = (state == ST_TIP);
  assign bpGate  = (state == ST_BP);

  // R5
  tip_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseEdge && tipGate |=> !tipGate && bpGate && tipCut);

  // R5
  cut_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    tipCut |=> !tipCut);

  // R6
  delay_cut_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseEdge && (state == ST_DELAY) |=> bpGate && !tipGate && !tipCut);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallEdge |=> !tipGate && !bpGate);

  // R3
  tip_from_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tipGate) |-> $past(state) == ST_DELAY);

  // R10
  gate_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tipGate, bpGate, tipCut && tipGate}));

endmodule

// File: rtl/sync_gate_timer.sv
module sync_gate_timer
  import sync_gate_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int TIP_DELAY_NS = 800,
  parameter int TIP_WIDTH_NS = 2000,
  parameter int BP_WIDTH_NS  = 2500,
  parameter int RATE_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [RATE_W-1:0] rateSel,
  output logic              tipGate,
  output logic              bpGate,
  output logic              tipCut
);

  localparam int DELAY_BASE = nsToCycles(CLK_HZ, TIP_DELAY_NS);
  localparam int TIP_BASE   = nsToCycles(CLK_HZ, TIP_WIDTH_NS);
  localparam int BP_BASE    = nsToCycles(CLK_HZ, BP_WIDTH_NS);
  localparam int MAX_BASE   = maxOf3(DELAY_BASE, TIP_BASE, BP_BASE);
  localparam int CNT_W      = $clog2(MAX_BASE + 2);

  ctlStrobe_t strobe;
  logic       fallEdge;
  logic       riseEdge;
  logic       cntLast;

  sync_gate_dp #(
    .RATE_W    (RATE_W),
    .CNT_W     (CNT_W),
    .DELAY_BASE(DELAY_BASE),
    .TIP_BASE  (TIP_BASE),
    .BP_BASE   (BP_BASE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .rateSel (rateSel),
    .strobe  (strobe),
    .fallEdge(fallEdge),
    .riseEdge(riseEdge),
    .cntLast (cntLast)
  );

  sync_gate_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .fallEdge(fallEdge),
    .riseEdge(riseEdge),
    .cntLast (cntLast),
    .strobe  (strobe),
    .tipGate (tipGate),
    .bpGate  (bpGate),
    .tipCut  (tipCut)
  );

endmodule

// File: tb/tb_sync_gate_timer.sv
module tb_sync_gate_timer;

  localparam int DELAY_BASE = 40;
  localparam int TIP_BASE   = 100;
  localparam int BP_BASE    = 125;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b1;
  logic [3:0] rateSel = 4'd1;
  logic       tipGate, bpGate, tipCut;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  // bench model state: edge times (in posedge counts) and loaded durations
  bit fV = 0, rV = 0;
  int fE = 0, rE = 0;
  int dC = 0, wC = 0, bC = 0;

  sync_gate_timer dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .rateSel(rateSel),
    .tipGate(tipGate), .bpGate(bpGate), .tipCut(tipCut)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int expCount(input int base, input int r);
    int q;
    q = base / ((r == 0) ? 1 : r);
    return (q < 1) ? 1 : q;
  endfunction

  task automatic check(input logic act, input logic exp, input string req, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic compareNow();
    int  c;
    bit  tipE, bpE, cutE;
    c = cyc;
    tipE = fV && (c >= fE + dC) && (c < fE + dC + wC) && !(rV && rE > fE && c >= rE);
    bpE  = rV && (c >= rE) && (c < rE + bC) && !(fV && fE > rE && c >= fE);
    cutE = fV && rV && (rE > fE) && (c == rE) && (rE - 1 >= fE + dC) && (rE - 1 < fE + dC + wC);
    check(tipGate, tipE, "R4", "tipGate (R3 R6 R8 R9 R2)");
    check(bpGate, bpE, "R7", "bpGate (R8 R9)");
    check(tipCut, cutE, "R5", "tipCut (R6)");
    check(tipGate & bpGate, 1'b0, "R10", "gate overlap");
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareNow();
    end
  endtask

  // drive one sync pulse: low for lowLen cycles, then high for highLen
  task automatic pulse(input int r, input int lowLen, input int highLen);
    rateSel = 4'(r);
    syncIn  = 1'b0;
    fV = 1; fE = cyc + 3;
    dC = expCount(DELAY_BASE, r);
    wC = expCount(TIP_BASE, r);
    step(lowLen);
    syncIn = 1'b1;
    rV = 1; rE = cyc + 3;
    bC = expCount(BP_BASE, r);
    step(highLen);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(tipGate, 1'b0, "R1", "tipGate in reset");
    check(bpGate, 1'b0, "R1", "bpGate in reset");
    check(tipCut, 1'b0, "R1", "tipCut in reset");
    rstN = 1'b1;
    step(5);
    // R3 R4 R7: full-width pulse at base rate
    pulse(1, 235, 400);
    // R5: trailing edge inside the tip window
    pulse(1, 80, 400);
    // R5: trailing edge one cycle after the tip opens
    pulse(1, 41, 300);
    // R6: trailing edge during the delay phase
    pulse(1, 20, 300);
    // R6: trailing edge right at the end of the delay
    pulse(1, 40, 300);
    // R8: next leading edge cuts the back-porch gate
    pulse(1, 235, 50);
    pulse(1, 235, 300);
    // R9: rate code zero acts as one
    pulse(0, 235, 300);
    // R9: highest divider, minimum counts
    pulse(15, 30, 30);
    pulse(15, 3, 3);
    pulse(4, 60, 100);
    // random mix
    for (int k = 0; k < 150; k++) begin
      int r, lo, hi;
      r  = int'($urandom % 16);
      lo = 2 + int'($urandom % 300);
      hi = 3 + int'($urandom % 350);
      pulse(r, lo, hi);
    end
    step(200);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule